// File: doc/BRIEF.md
# ARX Substitution Box Core

This block applies a 64-bit nonlinear substitution to one word. The word arrives as two 32-bit halves, `inX` and `inY`, together with a 32-bit round constant `inC`. The substitution runs four add-rotate-xor steps on the two halves and mixes the same constant into the left half at the end of every step. It uses only 32-bit modular addition, XOR and fixed rotations, so its latency never depends on the data.

A caller raises `start` while `ready` is high. Four rising edges after that acceptance edge, `done` pulses for one cycle and the transformed halves appear on `outX`/`outY`. They stay there until the next result replaces them. The parameter `ITERATIVE` selects the implementation. When it is 1, a single shared step circuit runs one step per clock and the core takes one operand at a time. When it is 0, four registered stages are chained, so a new operand can enter on every clock with the same latency.

Top module: `arxbox_core`

## Requirements
- R1: The result is the left and right halves after four steps, taken in step order 0 to 3. In each step, first x = x + (y rotated right by a), then y = y XOR (x rotated right by b), then x = x XOR c. The rotation pairs (a, b) for steps 0 to 3 are (31,24), (17,17), (0,31) and (24,16). The final x appears on `outX` and the final y on `outY`.
- R2: Every addition is taken modulo 2^32, and the carry out of bit 31 is dropped.
- R3: The constant `inC` captured at acceptance is XORed into x at the end of each of the four steps.
- R4: An acceptance edge is a rising edge at which `start` and `ready` are both high. `done` rises at the fourth rising edge after the acceptance edge and, in the iterative variant, falls at the next edge. The timing does not depend on the operand values.
- R5: In the iterative variant, `ready` is low from the acceptance edge until `done` rises. A `start` seen while `ready` is low is ignored: it neither changes the pending result nor produces an extra `done`.
- R6: `outX` and `outY` change only at an edge that raises `done`. Between results they hold their value.
- R7: Reset is synchronous and active low (`rstN`). While it is held, `done`, `outX` and `outY` read zero, and `ready` reads 1. Any operation in flight is abandoned.
- R8: In the pipelined variant (`ITERATIVE` = 0), `ready` stays at 1 and a new operand is accepted on every edge. Each operand gets its own `done` pulse, with the same latency as R4, and results come out in acceptance order.
- R9: An all-zero word with an all-zero constant maps to an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to accept the operand on the inputs |
| ready | output | 1 | Core can accept an operand this cycle |
| inX | input | 32 | Left half of the input word |
| inY | input | 32 | Right half of the input word |
| inC | input | 32 | Round constant for this evaluation |
| done | output | 1 | One-cycle pulse when a result is presented |
| outX | output | 32 | Left half of the result |
| outY | output | 32 | Right half of the result |

## Verification
The hardest case to reach is a second request that arrives while the iterative core is part way through its four steps. The bench drives `start` with different operands in the cycle right after acceptance. It then checks that the result still belongs to the first operand and that only one `done` follows. A reset asserted in mid-computation needs the same deliberate timing. For the pipelined variant, operands are streamed on consecutive edges so that all four stages are full at once, and each result is matched to the operand issued four edges earlier.

// File: rtl/arxbox_pkg.sv
package arxbox_pkg;

  localparam int WORD_W    = 32;
  localparam int NUM_STEPS = 4;
  localparam int STEP_W    = $clog2(NUM_STEPS);

  typedef logic [WORD_W-1:0] word_t;

  // control -> datapath strobes
  typedef struct packed {
    logic                 load;     // capture operand from ports
    logic [NUM_STEPS-1:0] stageEn;  // bit k: apply step k this edge
  } strobe_t;

  // rotation applied to y before the addition, per step
  function automatic int addRot(input int k);
    case (k)
      0:       return 31;
      1:       return 17;
      2:       return 0;
      default: return 24;
    endcase
  endfunction

  // rotation applied to x before the xor into y, per step
  function automatic int xorRot(input int k);
    case (k)
      0:       return 24;
      1:       return 17;
      2:       return 31;
      default: return 16;
    endcase
  endfunction

  // rotate right by a constant amount: pure rewiring after folding
  function automatic word_t rotRight(input word_t v, input int amt);
    if (amt == 0) return v;
    return (v >> amt) | (v << (WORD_W - amt));
  endfunction

endpackage

// File: rtl/arxbox_ctrl.sv
module arxbox_ctrl
  import arxbox_pkg::*;
#(
  parameter bit ITERATIVE = 1'b1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output logic    ready,
  output logic    done,
  output strobe_t strobe
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  generate
    if (ITERATIVE) begin : g_iter
      logic              busy;
      logic [STEP_W-1:0] stepCnt;
      logic              accept;
      logic [NUM_STEPS-1:0] stepHot;

      assign accept = start && !busy;
      assign ready  = !busy;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          busy    <= 1'b0;
          stepCnt <= '0;
          done    <= 1'b0;
        end else begin
          done <= busy && (stepCnt == LAST_STEP);
          if (accept) begin
            busy    <= 1'b1;
            stepCnt <= '0;
          end else if (busy) begin
            stepCnt <= stepCnt + STEP_W'(1);
            if (stepCnt == LAST_STEP) busy <= 1'b0;
          end
        end
      end

      always_comb begin
        stepHot = '0;
        if (busy) stepHot[stepCnt] = 1'b1;
      end

      assign strobe.load    = accept;
      assign strobe.stageEn = stepHot;
    end else begin : g_pipe
      logic [NUM_STEPS-1:0] stageVld;

      assign ready = 1'b1;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          stageVld <= '0;
          done     <= 1'b0;
        end else begin
          stageVld <= {stageVld[NUM_STEPS-2:0], start};
          done     <= stageVld[NUM_STEPS-1];
        end
      end

      assign strobe.load    = start;
      assign strobe.stageEn = stageVld;
    end
  endgenerate

endmodule

// File: rtl/arxbox_dpath.sv
module arxbox_dpath
  import arxbox_pkg::*;
#(
  parameter bit ITERATIVE = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [WORD_W-1:0] inX,
  input  logic [WORD_W-1:0] inY,
  input  logic [WORD_W-1:0] inC,
  output logic [WORD_W-1:0] outX,
  output logic [WORD_W-1:0] outY
);

  localparam int LAST = NUM_STEPS - 1;

  generate
    if (ITERATIVE) begin : g_iter
      word_t workX, workY, workC;
      word_t rotYTerm [NUM_STEPS];
      word_t rotXTerm [NUM_STEPS];
      word_t rotY, sumX, rotX, nextX, nextY;

      // one-hot AND-OR selection of the wired rotations
      for (genvar k = 0; k < NUM_STEPS; k++) begin : g_rot
        assign rotYTerm[k] = strobe.stageEn[k] ? rotRight(workY, addRot(k)) : '0;
        assign rotXTerm[k] = strobe.stageEn[k] ? rotRight(sumX, xorRot(k)) : '0;
      end

      always_comb begin
        rotY = '0;
        for (int k = 0; k < NUM_STEPS; k++) rotY = rotY | rotYTerm[k];
      end

      assign sumX = workX + rotY;

      always_comb begin
        rotX = '0;
        for (int k = 0; k < NUM_STEPS; k++) rotX = rotX | rotXTerm[k];
      end

      assign nextY = workY ^ rotX;
      assign nextX = sumX ^ workC;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          workX <= '0;
          workY <= '0;
          workC <= '0;
        end else if (strobe.load) begin
          workX <= inX;
          workY <= inY;
          workC <= inC;
        end else if (|strobe.stageEn) begin
          workX <= nextX;
          workY <= nextY;
        end
      end

      always_ff @(posedge clk) begin
        if (!rstN) begin
          outX <= '0;
          outY <= '0;
        end else if (strobe.stageEn[LAST]) begin
          outX <= nextX;
          outY <= nextY;
        end
      end
    end else begin : g_pipe
      word_t stX [NUM_STEPS];
      word_t stY [NUM_STEPS];
      word_t stC [NUM_STEPS];
      word_t nxX [NUM_STEPS];
      word_t nxY [NUM_STEPS];

      // one fixed-rotation step per stage
      for (genvar k = 0; k < NUM_STEPS; k++) begin : g_step
        word_t sumK;
        assign sumK   = stX[k] + rotRight(stY[k], addRot(k));
        assign nxY[k] = stY[k] ^ rotRight(sumK, xorRot(k));
        assign nxX[k] = sumK ^ stC[k];
      end

      always_ff @(posedge clk) begin
        if (!rstN) begin
          for (int k = 0; k < NUM_STEPS; k++) begin
            stX[k] <= '0;
            stY[k] <= '0;
            stC[k] <= '0;
          end
        end else begin
          if (strobe.load) begin
            stX[0] <= inX;
            stY[0] <= inY;
            stC[0] <= inC;
          end
          for (int k = 0; k < NUM_STEPS - 1; k++) begin
            if (strobe.stageEn[k]) begin
              stX[k+1] <= nxX[k];
              stY[k+1] <= nxY[k];
              stC[k+1] <= stC[k];
            end
          end
        end
      end

      always_ff @(posedge clk) begin
        if (!rstN) begin
          outX <= '0;
          outY <= '0;
        end else if (strobe.stageEn[LAST]) begin
          outX <= nxX[LAST];
          outY <= nxY[LAST];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/arxbox_core.sv
module arxbox_core
  import arxbox_pkg::*;
#(
  parameter bit ITERATIVE = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output logic        ready,
  input  logic [31:0] inX,
  input  logic [31:0] inY,
  input  logic [31:0] inC,
  output logic        done,
  output logic [31:0] outX,
  output logic [31:0] outY
);

  strobe_t strobe;

  arxbox_ctrl #(.ITERATIVE(ITERATIVE)) ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .ready  (ready),
    .done   (done),
    .strobe (strobe)
  );

  arxbox_dpath #(.ITERATIVE(ITERATIVE)) dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .inX    (inX),
    .inY    (inY),
    .inC    (inC),
    .outX   (outX),
    .outY   (outY)
  );

endmodule

// File: rtl/arxbox_core_chk.sv
module arxbox_core_chk #(
  parameter bit ITERATIVE = 1'b1
) (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        ready,
  input logic        done,
  input logic [31:0] outX,
  input logic [31:0] outY
);

  // R4
  done_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(start && ready, 5) |-> done);

  // R8
  done_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(start && ready, 5));

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(outX) && $stable(outY)));

  generate
    if (ITERATIVE) begin : g_iter
      // R4
      done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
        done |=> !done);

      // R5
      busy_block_chk: assert property (@(posedge clk) disable iff (!rstN)
        (start && ready) |=> !ready);
    end
  endgenerate

endmodule

bind arxbox_core arxbox_core_chk #(.ITERATIVE(ITERATIVE)) chk (.*);

// File: tb/arxbox_core_test.sv
module arxbox_core_test;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic        rstN = 1'b0;
  logic        start = 1'b0, pStart = 1'b0;
  logic [31:0] inX = '0, inY = '0, inC = '0;
  logic [31:0] pX = '0, pY = '0, pC = '0;
  logic        ready, done, pReady, pDone;
  logic [31:0] outX, outY, pOutX, pOutY;

  int checks = 0;
  int errors = 0;

  arxbox_core #(.ITERATIVE(1'b1)) uut (
    .clk(clk), .rstN(rstN), .start(start), .ready(ready),
    .inX(inX), .inY(inY), .inC(inC),
    .done(done), .outX(outX), .outY(outY)
  );

  arxbox_core #(.ITERATIVE(1'b0)) uutPipe (
    .clk(clk), .rstN(rstN), .start(pStart), .ready(pReady),
    .inX(pX), .inY(pY), .inC(pC),
    .done(pDone), .outX(pOutX), .outY(pOutY)
  );

  localparam int NVEC = 8;
  localparam logic [95:0] VECS [NVEC] = '{
    {32'h00000000, 32'h00000000, 32'h00000000},
    {32'hffffffff, 32'hffffffff, 32'hffffffff},
    {32'hffffffff, 32'h00000000, 32'h00000000},
    {32'h00000000, 32'hffffffff, 32'h00000000},
    {32'h00000000, 32'h00000000, 32'h5a3c96e1},
    {32'h01234567, 32'h89abcdef, 32'h0f1e2d3c},
    {32'h80000000, 32'h80000000, 32'h7777aaaa},
    {32'hdeadbeef, 32'h12345678, 32'hc001d00d}
  };

  function automatic logic [31:0] ror(input logic [31:0] v, input int n);
    logic [63:0] dbl;
    dbl = {v, v} >> n;
    return dbl[31:0];
  endfunction

  function automatic logic [63:0] refBox(input logic [31:0] x, input logic [31:0] y,
                                         input logic [31:0] c);
    int ra [4] = '{31, 17, 0, 24};
    int sa [4] = '{24, 17, 31, 16};
    for (int i = 0; i < 4; i++) begin
      x = x + ror(y, ra[i]);
      y = y ^ ror(x, sa[i]);
      x = x ^ c;
    end
    return {x, y};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one iterative evaluation; optional poke of start while busy
  task automatic runIter(input logic [31:0] x, input logic [31:0] y, input logic [31:0] c,
                         input string req, input bit poke);
    logic [63:0] exp;
    exp = refBox(x, y, c);
    start = 1'b1; inX = x; inY = y; inC = c;
    @(negedge clk);
    start = 1'b0;
    check(ready == 1'b0, "R5 ready after accept", 64'(ready), 64'd0);
    check(done == 1'b0, "R4 done early", 64'(done), 64'd0);
    if (poke) begin
      start = 1'b1; inX = ~x; inY = x ^ 32'h13579bdf; inC = ~c;
    end
    @(negedge clk);
    start = 1'b0;
    check(ready == 1'b0, "R5 ready mid-run", 64'(ready), 64'd0);
    @(negedge clk);
    @(negedge clk);
    check(done == 1'b0, "R4 done before fourth edge", 64'(done), 64'd0);
    @(negedge clk);
    check(done == 1'b1, "R4 done at fourth edge", 64'(done), 64'd1);
    check({outX, outY} == exp, req, {outX, outY}, exp);
    check(ready == 1'b1, "R5 ready after done", 64'(ready), 64'd1);
    @(negedge clk);
    check(done == 1'b0, "R4 done one cycle", 64'(done), 64'd0);
    check({outX, outY} == exp, "R6 result held", {outX, outY}, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R4 watchdog: actual=timeout expected=completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [95:0] pv [16];
    logic [63:0] held;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R7 reset state
    check(done == 1'b0 && outX == 0 && outY == 0, "R7 iterative reset outputs",
          {outX, outY}, 64'd0);
    check(ready == 1'b1, "R7 iterative ready after reset", 64'(ready), 64'd1);
    check(pDone == 1'b0 && pOutX == 0 && pOutY == 0, "R7 pipelined reset outputs",
          {pOutX, pOutY}, 64'd0);
    check(pReady == 1'b1, "R8 pipelined ready", 64'(pReady), 64'd1);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      string req;
      case (i)
        0:       req = "R9 zero word zero constant";
        1, 2, 3: req = "R2 carry wrap";
        4:       req = "R3 constant only";
        default: req = "R1 table vector";
      endcase
      runIter(VECS[i][95:64], VECS[i][63:32], VECS[i][31:0], req, 1'b0);
      if (i == 0) check({outX, outY} == 64'd0, "R9 zero result", {outX, outY}, 64'd0);
    end

    // randomized operands and constants
    for (int i = 0; i < 16; i++)
      runIter($urandom(), $urandom(), $urandom(), "R1 random vector", 1'b0);

    // start while busy is ignored
    runIter(32'h0badf00d, 32'h600dcafe, 32'h31415926, "R5 busy start ignored", 1'b1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(done == 1'b0, "R5 no extra done", 64'(done), 64'd0);
    end

    // outputs hold while inputs wander
    held = {outX, outY};
    for (int i = 0; i < 8; i++) begin
      inX = $urandom(); inY = $urandom(); inC = $urandom();
      @(negedge clk);
    end
    check({outX, outY} == held, "R6 hold without start", {outX, outY}, held);

    // pipelined stream, one operand per cycle
    for (int i = 0; i < 16; i++)
      pv[i] = (i < NVEC) ? VECS[i] : {$urandom(), $urandom(), $urandom()};
    for (int t = 0; t < 16 + 6; t++) begin
      if (t >= 5 && t - 5 < 16) begin
        logic [63:0] exp;
        exp = refBox(pv[t-5][95:64], pv[t-5][63:32], pv[t-5][31:0]);
        check(pDone == 1'b1, "R8 stream done", 64'(pDone), 64'd1);
        check({pOutX, pOutY} == exp, "R8 stream result", {pOutX, pOutY}, exp);
      end else if (t >= 1) begin
        check(pDone == 1'b0, "R8 stream idle", 64'(pDone), 64'd0);
      end
      check(pReady == 1'b1, "R8 always ready", 64'(pReady), 64'd1);
      if (t < 16) begin
        pStart = 1'b1; pX = pv[t][95:64]; pY = pv[t][63:32]; pC = pv[t][31:0];
      end else begin
        pStart = 1'b0;
      end
      @(negedge clk);
    end

    // reset in the middle of a computation
    start = 1'b1; inX = 32'h11112222; inY = 32'h33334444; inC = 32'h55556666;
    @(negedge clk);
    start = 1'b0;
    rstN = 1'b0;
    repeat (6) @(negedge clk);
    check(outX == 0 && outY == 0 && done == 1'b0, "R7 mid-run reset outputs",
          {outX, outY}, 64'd0);
    check(ready == 1'b1, "R7 mid-run reset ready", 64'(ready), 64'd1);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      check(done == 1'b0, "R7 abandoned run no done", 64'(done), 64'd0);
      @(negedge clk);
    end
    runIter(32'hfedcba98, 32'h76543210, 32'h00000001, "R1 after reset", 1'b0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule